// File: doc/BRIEF.md
# SPI Byte Shift Engine

This block is a synchronous serial master that exchanges one byte per transfer. On each accepted start it shifts a byte out on the data-out pin and, at the same time, collects a byte from the data-in pin, using a serial clock it derives from the system clock. A mode register chooses the bit order, the level the data-out pin rests at between transfers, and the serial clock edge that launches transmit data. It also chooses, separately, the edge that samples receive data, and whether transmitted and received bits are inverted.

Software writes the mode register through a single write strobe. It then pulses start with the transmit byte on `tx_byte`, and it collects `rx_byte` when `done` pulses. The serial clock rests at the level of the transmit polarity bit, so every bit period has a first half at the rest level, a mid edge, a second half and a closing edge back to rest. Transmit data always changes on the closing edge. This makes the closing edge falling when transmit polarity is 0 and rising when it is 1. The divisor is `2*HALF_DIV` system clocks per serial bit.

Top module: `spi_byte_engine`

## Requirements
- R1: Mode bit 1 picks the bit order: 1 sends and stores bit 7 first, 0 sends and stores bit 0 first. A byte shifted in through the same order ends up in `rx_byte` with its original bit weights.
- R2: Whenever `busy` is low, `spi_dout` equals mode bit 2, which is not subject to transmit inversion.
- R3: Mode bit 3 is the transmit polarity. `spi_clk` rests at its value. During a transfer `spi_dout` changes only on the edge where `spi_clk` returns to rest, which is falling for 0 and rising for 1. The first bit is already present when `busy` rises.
- R4: Mode bit 4 is the receive polarity: 0 samples `spi_din` on the rising edge and 1 on the falling edge of `spi_clk`.
- R5: Mode bit 5, when set, inverts every bit driven on `spi_dout` during a transfer.
- R6: Mode bit 6, when set, inverts every bit sampled from `spi_din` before it is stored.
- R7: A mode write while `busy` is high has no effect. A write while bit 0 (enable) is 1 and the engine is idle changes only the enable bit.
- R8: A mode write that leaves transmit polarity at 0 also leaves receive polarity at 0, whatever bit 4 of the write holds.
- R9: Each transfer keeps `busy` high for exactly `16*HALF_DIV` system clocks, which is eight serial clock periods of `2*HALF_DIV` clocks each.
- R10: `start` is accepted only when enable is 1 and `busy` is low. `busy` rises on the clock after an accepted start. Any other start has no effect.
- R11: `done` is high for exactly one clock, the clock in which `busy` first reads low, and `rx_byte` then holds the received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 7 | Mode write data: [0] enable, [1] msb first, [2] data-out rest level, [3] transmit polarity, [4] receive polarity, [5] transmit invert, [6] receive invert |
| start | input | 1 | Start strobe for one byte transfer |
| tx_byte | input | 8 | Byte to send, sampled on the accepted start |
| rx_byte | output | 8 | Last byte received |
| done | output | 1 | One-clock pulse at the end of a transfer |
| busy | output | 1 | High while a transfer runs |
| spi_clk | output | 1 | Serial clock |
| spi_dout | output | 1 | Serial data out |
| spi_din | input | 1 | Serial data in |

## Verification
A wrong bit counter or half-period counter shows up at once as a `busy` window that is not `16*HALF_DIV` clocks long, at the end of the very transfer it corrupts. A shift register that is misloaded or shifted the wrong way shows up as a wrong `rx_byte` at the `done` pulse and as a wrong bit on `spi_dout` within one bit period. Sampling on the wrong edge is caught within the same byte. The bench's slave drives the correct data bit only in the half period before the expected sample edge and its complement in the other half, so the stored byte comes out inverted. A mode field that changes when it should not shows up at the rest levels of `spi_clk` and `spi_dout` as soon as `busy` is low.

// File: rtl/spi_eng_pkg.sv
// Package: shared mode register layout for the SPI byte shift engine.
// Assumes: field order matches the write data bit positions (enable is bit 0).
package spi_eng_pkg;

    localparam int MODE_W = 7;

    typedef struct packed {
        logic rx_inv;     // bit 6
        logic tx_inv;     // bit 5
        logic rx_pol;     // bit 4
        logic tx_pol;     // bit 3
        logic dout_idle;  // bit 2
        logic msb_first;  // bit 1
        logic en;         // bit 0
    } mode_t;

endpackage

// File: rtl/spi_mode_reg.sv
// Module: spi_mode_reg
// Holds the mode fields. Writes are dropped while a transfer runs; while the
// engine is enabled and idle only the enable bit is writable; receive
// polarity can only be 1 together with transmit polarity.
// Assumes: busy comes from the sequencer and is registered.
module spi_mode_reg
    import spi_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_data,
    input  logic              busy,
    output mode_t             mode
);

    mode_t wr_mode;
    logic [MODE_W-1:0] mode_vec;

    assign wr_mode  = mode_t'(wr_data);
    assign mode_vec = mode;

    // Apply a write according to the current enable and busy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
        end else if (wr_en && !busy) begin
            if (!mode.en) begin
                mode        <= wr_mode;
                mode.rx_pol <= wr_mode.rx_pol & wr_mode.tx_pol;
            end else begin
                mode.en <= wr_mode.en;
            end
        end
    end

    // R7: nothing changes across a cycle that started busy
    assert_frozen_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode_vec));

    // R7: enabled and idle, only the enable bit may move
    assert_only_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.en && !busy) |=> $stable(mode_vec[MODE_W-1:1]));

    // R8: receive polarity never set without transmit polarity
    assert_rxpol_tied_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode.tx_pol |-> !mode.rx_pol);

endmodule

// File: rtl/spi_clk_gen.sv
// Module: spi_clk_gen
// Sequencer and serial clock divider. Each bit period is two halves of
// HALF_DIV system clocks; the clock leaves its rest level at the mid edge and
// returns at the closing edge. Strobes mark the cycle before each edge.
// Assumes: go is only asserted while busy is low.
module spi_clk_gen #(
    parameter int HALF_DIV = 2,
    parameter int DATA_W   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic idle_sclk,
    output logic busy,
    output logic sclk,
    output logic mid_stb,
    output logic end_stb,
    output logic last_stb
);

    localparam int CW  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BW  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int RUN = 2 * HALF_DIV * DATA_W;
    localparam int RW  = $clog2(RUN) + 1;

    logic [CW-1:0] hcnt;
    logic [BW-1:0] bitcnt;
    logic          half;
    logic          sclk_q;
    logic          wrap;
    logic [RW-1:0] run_cnt;

    assign wrap     = (hcnt == CW'(HALF_DIV - 1));
    assign mid_stb  = busy && wrap && !half;
    assign end_stb  = busy && wrap && half;
    assign last_stb = end_stb && (bitcnt == BW'(DATA_W - 1));
    assign sclk     = busy ? sclk_q : idle_sclk;

    // Count half periods and bits, toggle the serial clock at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            hcnt   <= '0;
            half   <= 1'b0;
            bitcnt <= '0;
            sclk_q <= 1'b0;
        end else if (go) begin
            busy   <= 1'b1;
            hcnt   <= '0;
            half   <= 1'b0;
            bitcnt <= '0;
            sclk_q <= idle_sclk;
        end else if (busy) begin
            if (wrap) begin
                hcnt   <= '0;
                half   <= ~half;
                sclk_q <= ~sclk_q;
                if (half) begin
                    if (bitcnt == BW'(DATA_W - 1)) busy <= 1'b0;
                    else                           bitcnt <= bitcnt + 1'b1;
                end
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    // Independent length counter used only by the check below.
    always_ff @(posedge clk) begin
        if (!rst_n)     run_cnt <= '0;
        else if (go)    run_cnt <= '0;
        else if (busy)  run_cnt <= run_cnt + 1'b1;
    end

    // R9: busy window is exactly 2*HALF_DIV*DATA_W cycles
    assert_busy_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt == RW'(RUN)));

endmodule

// File: rtl/spi_shifter.sv
// Module: spi_shifter
// Transmit and receive shift registers. Loads the first transmit bit on go,
// launches the next bit at each closing edge, stores sampled bits on the
// chosen sample strobe and presents the byte with a done pulse.
// Assumes: strobes come from spi_clk_gen; mode bits stay fixed while busy.
module spi_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              busy,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              msb_first,
    input  logic              tx_inv,
    input  logic              rx_inv,
    input  logic              end_stb,
    input  logic              last_stb,
    input  logic              smp_stb,
    input  logic              din,
    output logic              dout_q,
    output logic [DATA_W-1:0] rx_byte,
    output logic              done
);

    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_next_sh;
    logic [DATA_W-1:0] rx_ins;
    logic              first_bit;
    logic              next_bit;
    logic              rx_bit;

    // Select shift direction and the bits at each end from the order bit.
    always_comb begin
        rx_bit = din ^ rx_inv;
        if (msb_first) begin
            first_bit  = tx_byte[DATA_W-1];
            next_bit   = tx_sh[DATA_W-2];
            tx_next_sh = {tx_sh[DATA_W-2:0], 1'b0};
            rx_ins     = {rx_sh[DATA_W-2:0], rx_bit};
        end else begin
            first_bit  = tx_byte[0];
            next_bit   = tx_sh[1];
            tx_next_sh = {1'b0, tx_sh[DATA_W-1:1]};
            rx_ins     = {rx_bit, rx_sh[DATA_W-1:1]};
        end
    end

    // Shift, sample and present the finished byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_byte <= '0;
            dout_q  <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= last_stb;
            if (go) begin
                tx_sh  <= tx_byte;
                dout_q <= first_bit ^ tx_inv;
            end else if (end_stb && !last_stb) begin
                tx_sh  <= tx_next_sh;
                dout_q <= next_bit ^ tx_inv;
            end
            if (smp_stb) rx_sh <= rx_ins;
            if (last_stb) rx_byte <= smp_stb ? rx_ins : rx_sh;
        end
    end

    // R3: data out moves only at a closing edge while a transfer runs
    assert_launch_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !end_stb) |=> $stable(dout_q));

    // R11: done never lasts two cycles
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/spi_byte_engine.sv
// Module: spi_byte_engine (top)
// One-byte SPI master: mode register, clock sequencer and shift registers.
// Picks the sample strobe from the two polarity bits and holds the data-out
// pin at its programmed rest level outside transfers.
// Assumes: HALF_DIV >= 1 (divisor 2*HALF_DIV), DATA_W >= 2.
module spi_byte_engine
    import spi_eng_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [MODE_W-1:0] cfg_wdata,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    output logic [DATA_W-1:0] rx_byte,
    output logic              done,
    output logic              busy,
    output logic              spi_clk,
    output logic              spi_dout,
    input  logic              spi_din
);

    mode_t mode;
    logic  go;
    logic  mid_stb;
    logic  end_stb;
    logic  last_stb;
    logic  smp_stb;
    logic  sample_mid;
    logic  dout_q;

    assign go         = start && mode.en && !busy;
    assign sample_mid = (mode.rx_pol == mode.tx_pol);
    assign smp_stb    = sample_mid ? mid_stb : end_stb;
    assign spi_dout   = busy ? dout_q : mode.dout_idle;

    spi_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .busy    (busy),
        .mode    (mode)
    );

    spi_clk_gen #(.HALF_DIV(HALF_DIV), .DATA_W(DATA_W)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .idle_sclk (mode.tx_pol),
        .busy      (busy),
        .sclk      (spi_clk),
        .mid_stb   (mid_stb),
        .end_stb   (end_stb),
        .last_stb  (last_stb)
    );

    spi_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .busy      (busy),
        .tx_byte   (tx_byte),
        .msb_first (mode.msb_first),
        .tx_inv    (mode.tx_inv),
        .rx_inv    (mode.rx_inv),
        .end_stb   (end_stb),
        .last_stb  (last_stb),
        .smp_stb   (smp_stb),
        .din       (spi_din),
        .dout_q    (dout_q),
        .rx_byte   (rx_byte),
        .done      (done)
    );

    // R10: a transfer only begins after an enabled start strobe
    assert_start_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start && mode.en));

    // R11: the end of busy coincides with done
    assert_done_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

// File: tb/sim_spi_byte_engine.sv
module sim_spi_byte_engine;
    localparam int HD   = 2;
    localparam int DW   = 8;
    localparam int MW   = 7;
    localparam int XFER = 2 * HD * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [MW-1:0] cfg_wdata = '0;
    logic          start = 1'b0;
    logic [DW-1:0] tx_byte = '0;
    logic [DW-1:0] rx_byte;
    logic          done;
    logic          busy;
    logic          spi_clk;
    logic          spi_dout;
    logic          spi_din;

    spi_byte_engine #(.HALF_DIV(HD), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .start(start), .tx_byte(tx_byte), .rx_byte(rx_byte), .done(done),
        .busy(busy), .spi_clk(spi_clk), .spi_dout(spi_dout), .spi_din(spi_din)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // slave model state
    logic [DW-1:0] s_pat = '0;
    logic [DW-1:0] cap = '0;
    bit s_msb = 1'b0, s_idle = 1'b0, s_vh = 1'b0;
    int k = 0;
    int launch_err = 0;
    logic prev_sclk = 1'b0, prev_dout = 1'b0, prev_busy = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Slave: correct bit only in the half period before the expected sample edge.
    always @(negedge clk) begin
        logic h, b;
        if (busy) begin
            if (spi_clk != prev_sclk) begin
                if (spi_clk != s_idle) begin
                    if (k < DW) cap[k] = spi_dout;
                end else begin
                    k++;
                end
            end
            if (prev_busy && (spi_dout != prev_dout) &&
                !(spi_clk == s_idle && prev_sclk != s_idle))
                launch_err++;
            h = (spi_clk != s_idle);
            b = (k < DW) ? (s_msb ? s_pat[DW-1-k] : s_pat[k]) : 1'b0;
            spi_din = (h == s_vh) ? b : ~b;
        end else begin
            k = 0;
            spi_din = 1'b0;
        end
        prev_sclk = spi_clk;
        prev_dout = spi_dout;
        prev_busy = busy;
    end

    task automatic wr(input logic [MW-1:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // inj: 0 none, 1 extra start mid-transfer, 2 mode write mid-transfer
    task automatic run_xfer(input logic [MW-1:0] m, input logic [DW-1:0] tx,
                            input logic [DW-1:0] pat, input int inj,
                            input logic [MW-1:0] injv);
        logic eff_rx;
        logic [DW-1:0] exp_cap, exp_rx;
        int n;
        s_msb  = m[1];
        s_idle = m[3];
        eff_rx = m[4] & m[3];
        s_vh   = (eff_rx == m[3]) ? 1'b0 : 1'b1;
        s_pat  = pat;
        launch_err = 0;
        cap = '0;
        for (int i = 0; i < DW; i++)
            exp_cap[i] = (m[1] ? tx[DW-1-i] : tx[i]) ^ m[5];
        exp_rx = pat ^ (m[6] ? '1 : '0);
        wr(m & ~MW'(1));
        wr(m | MW'(1));
        check(spi_clk == m[3], "R3 clock rest level", spi_clk, m[3]);
        check(spi_dout == m[2], "R2 dout rest before", spi_dout, m[2]);
        tx_byte = tx;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (busy && n < 1000) begin
            n++;
            if (n == 4) begin
                if (inj == 1) start = 1'b1;
                if (inj == 2) begin cfg_we = 1'b1; cfg_wdata = injv; end
            end
            if (n == 5) begin start = 1'b0; cfg_we = 1'b0; end
            @(negedge clk);
        end
        check(n == XFER, "R9 busy length", n, XFER);
        check(done == 1'b1, "R11 done at end", done, 1);
        check(rx_byte == exp_rx, "R1 R4 R6 R8 received byte", rx_byte, exp_rx);
        check(cap == exp_cap, "R1 R5 transmitted bits", cap, exp_cap);
        check(launch_err == 0, "R3 launch edge", launch_err, 0);
        check(spi_dout == m[2], "R2 R7 dout rest after", spi_dout, m[2]);
        check(spi_clk == m[3], "R3 R7 clock rest after", spi_clk, m[3]);
        @(negedge clk);
        check(done == 1'b0, "R11 done single", done, 0);
        check(busy == 1'b0, "R10 no restart", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R9 watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R10 reset busy", busy, 0);
        check(done == 1'b0, "R11 reset done", done, 0);
        check(spi_clk == 1'b0, "R3 reset clock", spi_clk, 0);
        check(spi_dout == 1'b0, "R2 reset dout", spi_dout, 0);

        // R10: start while disabled
        wr(7'b0000000);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0, "R10 start while disabled", busy, 0);
        @(negedge clk);
        check(busy == 1'b0, "R10 start while disabled later", busy, 0);

        // Sweep every mode combination, three byte pairs each.
        for (int c = 0; c < 64; c++) begin
            for (int j = 0; j < 3; j++) begin
                logic [MW-1:0] m;
                m = {c[5], c[4], c[3], c[2], c[1], c[0], 1'b1};
                run_xfer(m, DW'(8'h5A ^ (c * 37 + j * 91)),
                         DW'(8'hC3 + c * 13 + j * 71), 0, '0);
            end
        end

        // R10: extra start during a transfer
        run_xfer(7'b0011011, 8'hA5, 8'h3C, 1, '0);
        // R7: mode write during a transfer (flip rest level and polarity)
        run_xfer(7'b0011011, 8'h96, 8'h0F, 2, 7'b0000101);

        // R7: enabled and idle, only enable changes
        wr(7'b0000000);
        wr(7'b0001101);
        check(spi_clk == 1'b1, "R3 clock rest high", spi_clk, 1);
        check(spi_dout == 1'b1, "R2 dout rest high", spi_dout, 1);
        wr(7'b0000001);
        check(spi_clk == 1'b1, "R7 polarity kept when enabled", spi_clk, 1);
        check(spi_dout == 1'b1, "R7 rest level kept when enabled", spi_dout, 1);
        wr(7'b0000000);
        check(spi_clk == 1'b1, "R7 polarity kept on disable", spi_clk, 1);
        check(spi_dout == 1'b1, "R7 rest level kept on disable", spi_dout, 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0, "R10 start after disable", busy, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule